// File: doc/BRIEF.md
# Constrained Rep-Rate Pattern Generator

The block decides which of the 600 machine cycles in a ten-second super cycle should fire one timed event. A request carries a wanted rate in tenths of a hertz, a placement mode, a 600-bit constraint pattern and a signed offset. In the first mode the wanted number of firings is spread evenly across the super cycle, and the constraint and offset play no part. In the second mode the firings are taken from the set pulses of the constraint pattern and moved by the offset. The constraint can be the output of another instance or a logical mix of several patterns. The block reports the resulting pattern and the rate it actually reached, which is the number of set bits.

Computation is sequential and walks one cycle index per clock. The second mode first spends one pass counting the constraint pulses and then a second pass placing them. A request is taken on a `req_valid`/`req_ready` handshake. `req_ready` is high only while the engine is idle. While it is low, the source must hold `req_valid` and the request fields stable until the request is taken. A finished pattern is held as pending. The event gate uses it only from the next strobe whose cycle index is 0, so a super cycle never runs on a mix of old and new patterns.

Top module: `reprate_pattern_gen`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the computation ends. `done_o` is a single-cycle pulse, and `pattern_o` and `rate_o` already hold the new result in the cycle where it is high.
- R2: `req_rate` is in units of 0.1 Hz. Any value above 600 is treated as 600. `rate_o` equals the number of set bits in `pattern_o`.
- R3: With `req_mode` = 0 (fixed), an accumulator starts at 0. For each index i from 0 up to 599 it adds the rate. Whenever the sum reaches 600 or more, 600 is removed and bit i is set. `req_cons` and `req_offset` have no effect.
- R4: With `req_mode` = 1 (variable), let N be the number of set bits in the constraint and k the smaller of the rate and N. The constraint pulses are visited in ascending index order. An accumulator starting at 0 adds k at each pulse, and a pulse is selected whenever the sum reaches N, at which point N is removed. If k is at least N, every pulse is selected. If N is 0, nothing is selected.
- R5: In variable mode a pulse selected at index i sets bit (i + offset) mod 600. `req_offset` is an 11-bit two's-complement value in the range -599 to 599. A negative value places the event before the constraint pulse and zero places it on the pulse.
- R6: A new pattern drives events only from the first strobe with `cyc_idx` = 0 after `done_o`. Strobes at other indices keep using the previously active pattern.
- R7: `evt_o` is high one clock after a `cyc_strobe` whose `cyc_idx` selects a set bit of the active pattern. It is low after a cycle without a strobe, and low for any index of 600 or more.
- R8: After reset `req_ready` is 1. `done_o`, `evt_o`, `rate_o` and `pattern_o` are 0, and the active pattern is empty.
- R9: The constraint pattern is captured when the request is taken. Changing `req_cons` while the computation runs does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_mode | input | 1 | 0 fixed spreading, 1 constraint-relative |
| req_rate | input | 10 | Wanted rate in 0.1 Hz |
| req_offset | input | 11 | Signed placement offset in cycles |
| req_cons | input | 600 | Constraint pattern, bit i = cycle i |
| done_o | output | 1 | One-cycle pulse when a new result is posted |
| pattern_o | output | 600 | Last computed pattern |
| rate_o | output | 10 | Achieved rate in 0.1 Hz |
| cyc_strobe | input | 1 | A machine cycle starts |
| cyc_idx | input | 10 | Index of that cycle in the super cycle |
| evt_o | output | 1 | Event enable for the strobed cycle |

## Verification
The bench targets the rate boundaries 0, 600 and above 600. A design that fails to clamp would overflow the accumulator and post a rate that does not match its own bit count. It also targets a constraint with no pulses, a single pulse at index 599 pushed past the end, and a negative offset. Wrong modulo arithmetic would drop the pulse or place it at the wrong cycle, and a zero-pulse constraint could cause a divide-by-zero style runaway. Other cases are a pattern committed in the middle of a super cycle and a constraint input that changes while the engine is busy. A design that swaps patterns too early would fire events from the new pattern before index 0. A design that does not capture the constraint would mix the two constraint values into one pattern.

// File: rtl/rrp_pkg.sv
`timescale 1ns/1ps
package rrp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PLACE = 2'd2
  } rrp_state_e;
endpackage

// File: rtl/rrp_engine.sv
`timescale 1ns/1ps
// Sequential placement engine: optional counting pass, then a placing pass.
module rrp_engine
  import rrp_pkg::*;
#(
  parameter int CYCLES = 600,
  parameter int IW = 10,
  parameter int RW = 10,
  parameter int OW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_mode,
  input  logic [RW-1:0]        req_rate,
  input  logic signed [OW-1:0] req_offset,
  input  logic [CYCLES-1:0]    req_cons,
  output logic                 clr_o,
  output logic                 set_o,
  output logic [IW-1:0]        pos_o,
  output logic                 fin_o,
  output logic [RW-1:0]        rate_o
);
  localparam logic [IW-1:0] LAST  = IW'(CYCLES - 1);
  localparam logic [RW-1:0] CYC_R = RW'(CYCLES);
  localparam logic [IW:0]   CYC_P = (IW+1)'(CYCLES);

  rrp_state_e          st;
  logic [CYCLES-1:0]   cons_q;
  logic                mode_q;
  logic [RW-1:0]       rate_q, ncnt, acc, fcnt, rate_res;
  logic [IW-1:0]       offn_q, idx;
  logic                fin_q;

  // combinational step terms
  logic [RW-1:0] den, k, shift_den;
  logic [RW:0]   sum;
  logic          elig, fire;
  logic [IW-1:0] shift;
  logic [IW:0]   psum;

  always_comb begin
    den   = mode_q ? ncnt : CYC_R;
    k     = (rate_q < den) ? rate_q : den;
    elig  = mode_q ? cons_q[idx] : 1'b1;
    sum   = {1'b0, acc} + {1'b0, k};
    fire  = (st == ST_PLACE) && elig && (den != '0) && (sum >= {1'b0, den});
    shift_den = fire ? den : '0;
    shift = mode_q ? offn_q : '0;
    psum  = {1'b0, idx} + {1'b0, shift};
    pos_o = (psum >= CYC_P) ? IW'(psum - CYC_P) : IW'(psum);
  end

  assign req_ready = (st == ST_IDLE);
  assign clr_o     = (st == ST_IDLE) && req_valid;
  assign set_o     = fire;
  assign fin_o     = fin_q;
  assign rate_o    = rate_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cons_q   <= '0;
      mode_q   <= 1'b0;
      rate_q   <= '0;
      offn_q   <= '0;
      idx      <= '0;
      ncnt     <= '0;
      acc      <= '0;
      fcnt     <= '0;
      rate_res <= '0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= (st == ST_PLACE) && (idx == LAST);
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cons_q <= req_cons;
          mode_q <= req_mode;
          rate_q <= (req_rate > CYC_R) ? CYC_R : req_rate;
          offn_q <= req_offset[OW-1] ? IW'(req_offset + OW'(CYCLES)) : IW'(req_offset);
          idx    <= '0;
          ncnt   <= '0;
          acc    <= '0;
          fcnt   <= '0;
          st     <= req_mode ? ST_COUNT : ST_PLACE;
        end
        ST_COUNT: begin
          ncnt <= ncnt + RW'(cons_q[idx]);
          if (idx == LAST) begin
            idx <= '0;
            st  <= ST_PLACE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PLACE: begin
          if (elig && (den != '0)) acc <= RW'(sum - {1'b0, shift_den});
          fcnt <= fcnt + RW'(fire);
          if (idx == LAST) begin
            rate_res <= fcnt + RW'(fire);
            st       <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrp_bank.sv
`timescale 1ns/1ps
// Work, pending and active pattern storage plus the per-cycle event gate.
module rrp_bank #(
  parameter int CYCLES = 600,
  parameter int IW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [IW-1:0]     pos_i,
  input  logic              fin_i,
  input  logic              cyc_strobe,
  input  logic [IW-1:0]     cyc_idx,
  output logic [CYCLES-1:0] pattern_o,
  output logic              done_o,
  output logic              evt_o
);
  logic [CYCLES-1:0] work, pend, act;
  logic              pend_v, done_q, evt_q;
  logic              boundary, use_pend, idx_ok;
  logic [IW-1:0]     sel;

  for (genvar g = 0; g < CYCLES; g++) begin : g_work
    always_ff @(posedge clk) begin
      if (!rst_n)                              work[g] <= 1'b0;
      else if (clr_i)                          work[g] <= 1'b0;
      else if (set_i && (pos_i == IW'(g)))     work[g] <= 1'b1;
    end
  end

  always_comb begin
    idx_ok   = (cyc_idx < IW'(CYCLES));
    sel      = idx_ok ? cyc_idx : '0;
    boundary = cyc_strobe && (cyc_idx == '0);
    use_pend = (cyc_idx == '0) && pend_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      act    <= '0;
      pend_v <= 1'b0;
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (boundary && pend_v) act <= pend;
      if (fin_i) begin
        pend   <= work;
        pend_v <= 1'b1;
      end else if (boundary) begin
        pend_v <= 1'b0;
      end
      evt_q <= cyc_strobe && idx_ok && (use_pend ? pend[sel] : act[sel]);
    end
  end

  assign pattern_o = pend;
  assign done_o    = done_q;
  assign evt_o     = evt_q;
endmodule

// File: rtl/reprate_pattern_gen.sv
`timescale 1ns/1ps
module reprate_pattern_gen #(
  parameter int CYCLES = 600,
  localparam int IW = $clog2(CYCLES),
  localparam int RW = $clog2(CYCLES + 1),
  localparam int OW = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_mode,
  input  logic [RW-1:0]        req_rate,
  input  logic signed [OW-1:0] req_offset,
  input  logic [CYCLES-1:0]    req_cons,
  output logic                 done_o,
  output logic [CYCLES-1:0]    pattern_o,
  output logic [RW-1:0]        rate_o,
  input  logic                 cyc_strobe,
  input  logic [IW-1:0]        cyc_idx,
  output logic                 evt_o
);
  logic          clr, set, fin;
  logic [IW-1:0] pos;

  rrp_engine #(.CYCLES(CYCLES), .IW(IW), .RW(RW), .OW(OW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_rate(req_rate),
    .req_offset(req_offset), .req_cons(req_cons),
    .clr_o(clr), .set_o(set), .pos_o(pos), .fin_o(fin), .rate_o(rate_o)
  );

  rrp_bank #(.CYCLES(CYCLES), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .clr_i(clr), .set_i(set), .pos_i(pos), .fin_i(fin),
    .cyc_strobe(cyc_strobe), .cyc_idx(cyc_idx),
    .pattern_o(pattern_o), .done_o(done_o), .evt_o(evt_o)
  );
endmodule

// File: rtl/reprate_pattern_gen_chk.sv
`timescale 1ns/1ps
module reprate_pattern_gen_chk #(
  parameter int CYCLES = 600,
  parameter int RW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done_o,
  input logic [RW-1:0]     rate_o,
  input logic [CYCLES-1:0] pattern_o,
  input logic              cyc_strobe,
  input logic              evt_o
);
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready);
  p_rate_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_o <= RW'(CYCLES));
  p_rate_popcount_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rate_o == RW'($countones(pattern_o))));
  p_pattern_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pattern_o));
  p_evt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> !evt_o);
endmodule

bind reprate_pattern_gen reprate_pattern_gen_chk #(.CYCLES(CYCLES), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done_o(done_o), .rate_o(rate_o), .pattern_o(pattern_o),
  .cyc_strobe(cyc_strobe), .evt_o(evt_o)
);

// File: tb/reprate_pattern_gen_tb.sv
`timescale 1ns/1ps
module reprate_pattern_gen_tb;
  localparam int C = 600;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_mode = 1'b0;
  logic [9:0]        req_rate = '0;
  logic signed [10:0] req_offset = '0;
  logic [C-1:0]      req_cons = '0;
  logic              done_o;
  logic [C-1:0]      pattern_o;
  logic [9:0]        rate_o;
  logic              cyc_strobe = 1'b0;
  logic [9:0]        cyc_idx = '0;
  logic              evt_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  reprate_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_rate(req_rate), .req_offset(req_offset),
    .req_cons(req_cons), .done_o(done_o), .pattern_o(pattern_o),
    .rate_o(rate_o), .cyc_strobe(cyc_strobe), .cyc_idx(cyc_idx), .evt_o(evt_o)
  );

  // {mode, rate, offset(11b two's complement), constraint kind, expected rate}
  // kind: 0 none, 1 every 10th from 0, 2 every 3rd from 1, 3 only index 599
  localparam logic [33:0] VEC [10] = '{
    {1'b0, 10'd600, 11'h000, 2'd0, 10'd600},
    {1'b0, 10'd0,   11'h000, 2'd0, 10'd0},
    {1'b0, 10'd10,  11'h000, 2'd0, 10'd10},
    {1'b0, 10'd700, 11'h000, 2'd0, 10'd600},
    {1'b1, 10'd600, 11'h000, 2'd1, 10'd60},
    {1'b1, 10'd30,  11'h7FD, 2'd1, 10'd30},   // offset -3
    {1'b1, 10'd20,  11'h005, 2'd2, 10'd20},
    {1'b1, 10'd5,   11'h002, 2'd3, 10'd1},
    {1'b1, 10'd100, 11'h000, 2'd0, 10'd0},
    {1'b0, 10'd50,  11'h007, 2'd1, 10'd50}
  };

  function automatic logic [C-1:0] gen(input logic [1:0] kind);
    logic [C-1:0] p = '0;
    for (int i = 0; i < C; i++) begin
      case (kind)
        2'd1: p[i] = (i % 10 == 0);
        2'd2: p[i] = (i % 3 == 1);
        2'd3: p[i] = (i == C - 1);
        default: p[i] = 1'b0;
      endcase
    end
    return p;
  endfunction

  function automatic logic [C-1:0] model(input logic m, input logic [9:0] r,
                                         input logic signed [10:0] o, input logic [C-1:0] cn);
    logic [C-1:0] p = '0;
    int rr = (r > 600) ? 600 : int'(r);
    int n = 0;
    int den, kk, acc, sh;
    for (int i = 0; i < C; i++) n += int'(cn[i]);
    den = m ? n : C;
    kk  = (rr < den) ? rr : den;
    sh  = m ? int'(o) : 0;
    if (sh < 0) sh += C;
    acc = 0;
    for (int i = 0; i < C; i++) begin
      if ((m ? cn[i] : 1'b1) && den > 0) begin
        acc += kk;
        if (acc >= den) begin
          acc -= den;
          p[(i + sh) % C] = 1'b1;
        end
      end
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic m, input logic [9:0] r, input logic signed [10:0] o,
                         input logic [C-1:0] cn, input bit swap, input logic [C-1:0] cn2,
                         output bit busy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_rate = r; req_offset = o; req_cons = cn;
    @(negedge clk);
    req_valid = 1'b0;
    if (swap) req_cons = cn2;
    busy = !req_ready;
    while (!done_o) @(negedge clk);
  endtask

  task automatic sweep(input logic [C-1:0] exp, output int errs);
    errs = 0;
    for (int i = 0; i < C; i++) begin
      @(negedge clk);
      if (i > 0 && evt_o !== exp[i-1]) errs++;
      cyc_idx = 10'(i); cyc_strobe = 1'b1;
    end
    @(negedge clk);
    if (evt_o !== exp[C-1]) errs++;
    cyc_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [C-1:0] exp_p, last_p, new_p;
    bit busy;
    int errs;

    repeat (4) @(negedge clk);
    // R8: reset state
    chk(req_ready === 1'b1, "R8 ready", int'(req_ready), 1);
    chk(done_o === 1'b0 && evt_o === 1'b0, "R8 done/evt", int'(done_o) + int'(evt_o), 0);
    chk(pattern_o === '0 && rate_o === '0, "R8 pattern/rate", $countones(pattern_o) + int'(rate_o), 0);
    rst_n = 1'b1;
    // R7/R8: an empty active pattern gives no event even on a strobe
    @(negedge clk); cyc_idx = 10'd0; cyc_strobe = 1'b1;
    @(negedge clk); cyc_strobe = 1'b0;
    chk(evt_o === 1'b0, "R8 empty active", int'(evt_o), 0);

    for (int v = 0; v < 10; v++) begin
      logic [C-1:0] cn;
      cn = gen(VEC[v][11:10]);
      exp_p = model(VEC[v][33], VEC[v][32:23], VEC[v][22:12], cn);
      run_req(VEC[v][33], VEC[v][32:23], VEC[v][22:12], cn, 1'b0, '0, busy);
      if (v == 0) chk(busy, "R1 ready low while busy", int'(!busy), 0);
      chk(pattern_o === exp_p, VEC[v][33] ? "R4/R5 pattern" : "R3 pattern",
          $countones(pattern_o ^ exp_p), 0);
      chk(rate_o === VEC[v][9:0], "R2 achieved rate", int'(rate_o), int'(VEC[v][9:0]));
      if (v == 7) chk(pattern_o[1] === 1'b1, "R5 wrap past end", int'(pattern_o[1]), 1);
      @(negedge clk);
      if (v == 0) chk(done_o === 1'b0, "R1 done single pulse", int'(done_o), 0);
      last_p = exp_p;
    end

    // R5: negative offset lands before the constraint pulse
    run_req(1'b1, 10'd600, -11'sd3, gen(2'd1), 1'b0, '0, busy);
    chk(pattern_o[597] === 1'b1 && pattern_o[0] === 1'b0, "R5 negative offset",
        int'(pattern_o[597]), 1);
    // restore the fixed-rate-50 pattern as pending
    run_req(1'b0, 10'd50, 11'sd7, gen(2'd1), 1'b0, '0, busy);

    // R7: sweep a full super cycle with the pending pattern taking effect at index 0
    sweep(last_p, errs);
    chk(errs == 0, "R7 event gate sweep", errs, 0);
    @(negedge clk); cyc_idx = 10'd600; cyc_strobe = 1'b1;
    @(negedge clk); cyc_strobe = 1'b0;
    chk(evt_o === 1'b0, "R7 index out of range", int'(evt_o), 0);
    @(negedge clk); cyc_idx = 10'd11;
    @(negedge clk);
    chk(evt_o === 1'b0, "R7 no strobe", int'(evt_o), 0);

    // R9: constraint swapped while busy must not matter
    new_p = gen(2'd1);
    run_req(1'b1, 10'd600, 11'sd0, gen(2'd1), 1'b1, gen(2'd2), busy);
    chk(pattern_o === new_p, "R9 constraint captured", $countones(pattern_o ^ new_p), 0);

    // R6: mid-cycle strobe still uses the old active pattern
    @(negedge clk); cyc_idx = 10'd11; cyc_strobe = 1'b1;
    @(negedge clk); cyc_strobe = 1'b0;
    chk(evt_o === last_p[11], "R6 old pattern before boundary", int'(evt_o), int'(last_p[11]));
    sweep(new_p, errs);
    chk(errs == 0, "R6 new pattern after boundary", errs, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule